// File: doc/BRIEF.md
# Speculative Load/Store Ordering Buffer

This block sits between a ring of task-executing processing elements and memory. Tasks run out of order with respect to each other but must appear to run in ring order, starting at the head task. Loads never wait for earlier tasks. Each load takes its value from the nearest earlier task that has buffered a store to the same word address. If there is no such store, the value comes from memory. A load that reads its address before its own task has stored there is recorded in the table, because a later store by an earlier task could prove that load stale.

A store never reaches memory while its task is speculative. The store value is kept in a per-task slot of a small fully associative table. The table is searched for a later task that has already loaded the same address. If one is found and no task in between has stored to that address, the earliest such task is reported for squash. Its records, and those of every task after it, are wiped. When the head task is told to commit, its buffered stores are written to memory one per cycle, lowest table slot first. The head then moves to the next task in the ring.

Top module: `spec_ls_buffer`

## Requirements
- R1: A load that is accepted (`opReady` high) returns `rdValid` high one cycle later. Its data comes from memory (`memRdData` at `memRdAddr`) when no task up to and including the loader, in ring order from the head, holds a buffered store to that address.
- R2: A store never drives `memWrEn`. Its value is held in the table until its task commits as head.
- R3: A load returns the buffered store value of the closest task at or before the loader in ring order, where ring position is (task − head) mod NUM_TASKS. This includes wrap-around past task NUM_TASKS−1.
- R4: A store by task T checks the later tasks in ring order, nearest first. It raises `squashValid` for one cycle, one cycle after the store, with `squashTask` set to the first later task that has a recorded load at that address.
- R5: On a squash, all load records and buffered stores of the squashed task and of every later task are cleared. Later loads by those tasks see only earlier tasks' stores or memory.
- R6: A load by a task that already has its own buffered store at that address is not recorded, so a later store by an earlier task does not squash it for that load.
- R7: A `commitReq` pulse stalls all operations (`opReady` low) from the cycle it is raised. The head's buffered stores are then written to memory one per cycle, in ascending table-slot order (slots are allocated lowest free first). The head's load records are cleared and `headTask` advances by one.
- R8: When all ENTRIES slots are in use, an operation to a new address is refused (`opReady` low). An operation to an address already in the table is still accepted.
- R9: Reset (`rstN` low) gives `headTask` = 0, an empty table, `opReady` high, and `rdValid`, `squashValid` and `memWrEn` low.
- R10: The search for a violating load stops at the first later task that has itself stored to the address, so loads beyond that task are not squashed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Load or store request present |
| opIsStore | input | 1 | 1 = store, 0 = load |
| opTask | input | TASK_W | Issuing task number |
| opAddr | input | ADDR_W | Word address |
| opData | input | DATA_W | Store value |
| opReady | output | 1 | Request accepted this cycle |
| rdValid | output | 1 | Load result valid (one cycle after accept) |
| rdData | output | DATA_W | Load result |
| squashValid | output | 1 | Ordering violation pulse |
| squashTask | output | TASK_W | Earliest task to squash |
| commitReq | input | 1 | Commit the head task |
| headTask | output | TASK_W | Current head (oldest) task |
| memRdAddr | output | ADDR_W | Memory read address (combinational) |
| memRdData | input | DATA_W | Memory read data (same cycle) |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | ADDR_W | Memory write address |
| memWrData | output | DATA_W | Memory write data |

## Verification
The hardest situation to reach is a store whose search must tell three later-task cases apart: an exposed load, a load that came after that task's own store, and a task in between that shields the rest. The vector table builds these states in turn on one word. Loads and stores from several tasks are interleaved so that one squash leaves behind the exact record pattern the next store probes. The bench then commits the head and issues a load from the new youngest task, which makes the forwarding search wrap around the ring.

// File: rtl/specbuf_pkg.sv
package specbuf_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_DRAIN
  } bufState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;
    logic storeEn;
    logic drainWrEn;
    logic retireEn;
  } bufStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic hit;
    logic freeAvail;
    logic headHasStore;
    logic violation;
  } bufStatus_t;

endpackage

// File: rtl/specbuf_ctrl.sv
module specbuf_ctrl
  import specbuf_pkg::*;
#(
  parameter int TASK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic              opIsStore,
  input  logic              commitReq,
  input  bufStatus_t        status,
  input  logic [TASK_W-1:0] violTask,
  output bufStrobe_t        strobe,
  output logic [TASK_W-1:0] head,
  output logic              opReady,
  output logic              squashValid,
  output logic [TASK_W-1:0] squashTask
);

  bufState_e state;

  always_comb begin
    opReady = (state == ST_IDLE) && !commitReq && (status.hit || status.freeAvail);
    strobe.loadEn    = opValid && opReady && !opIsStore;
    strobe.storeEn   = opValid && opReady && opIsStore;
    strobe.drainWrEn = (state == ST_DRAIN) && status.headHasStore;
    strobe.retireEn  = (state == ST_DRAIN) && !status.headHasStore;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      head        <= '0;
      squashValid <= 1'b0;
      squashTask  <= '0;
    end else begin
      squashValid <= strobe.storeEn && status.violation;
      if (strobe.storeEn && status.violation) squashTask <= violTask;
      case (state)
        ST_IDLE:  if (commitReq) state <= ST_DRAIN;
        ST_DRAIN: if (strobe.retireEn) begin
          state <= ST_IDLE;
          head  <= head + TASK_W'(1);
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // head only ever steps forward by one task
  assert_head_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (head != $past(head)) |-> (head == $past(head) + TASK_W'(1)));

  // a victim is always behind the head, never the head itself
  assert_squash_not_head_R4: assert property (@(posedge clk) disable iff (!rstN)
    squashValid |-> (squashTask != head));

  // no load or store is taken while draining
  assert_drain_blocks_ops_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.drainWrEn |-> !(strobe.loadEn || strobe.storeEn));

endmodule

// File: rtl/specbuf_data.sv
module specbuf_data
  import specbuf_pkg::*;
#(
  parameter int NUM_TASKS = 4,
  parameter int ENTRIES   = 16,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  localparam int TASK_W   = $clog2(NUM_TASKS),
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobe_t        strobe,
  input  logic [TASK_W-1:0] head,
  input  logic [TASK_W-1:0] opTask,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  input  logic [DATA_W-1:0] memRdData,
  output bufStatus_t        status,
  output logic [TASK_W-1:0] violTask,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);

  logic [ADDR_W-1:0]    tagQ [ENTRIES];
  logic [NUM_TASKS-1:0] ldQ  [ENTRIES];
  logic [NUM_TASKS-1:0] stQ  [ENTRIES];
  logic [DATA_W-1:0]    valQ [ENTRIES][NUM_TASKS];

  logic [ENTRIES-1:0]   liveVec;
  logic [TASK_W-1:0]    taskAt [NUM_TASKS];
  logic [TASK_W-1:0]    opPos;
  logic                 hit, freeAvail, headHasStore;
  logic [IDX_W-1:0]     hitIdx, freeIdx, selIdx, drainIdx;
  logic                 fwdHit, ownStore, violation, blocked;
  logic [DATA_W-1:0]    fwdVal, loadValue;
  logic [TASK_W-1:0]    violPos;
  logic [NUM_TASKS-1:0] clrMask;

  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_live
      assign liveVec[gi] = (|ldQ[gi]) || (|stQ[gi]);
    end
    for (gi = 0; gi < NUM_TASKS; gi++) begin : g_ring
      assign taskAt[gi]  = head + TASK_W'(gi);
      assign clrMask[gi] = (TASK_W'(gi) - head) >= violPos;
    end
  endgenerate

  assign opPos = opTask - head;

  // associative lookup, lowest slot wins
  always_comb begin
    hit = 1'b0; hitIdx = '0; freeAvail = 1'b0; freeIdx = '0;
    headHasStore = 1'b0; drainIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (liveVec[i] && tagQ[i] == opAddr) begin
        hit = 1'b1; hitIdx = IDX_W'(i);
      end
      if (!liveVec[i]) begin
        freeAvail = 1'b1; freeIdx = IDX_W'(i);
      end
      if (stQ[i][head]) begin
        headHasStore = 1'b1; drainIdx = IDX_W'(i);
      end
    end
  end

  assign selIdx   = hit ? hitIdx : freeIdx;
  assign ownStore = hit && stQ[hitIdx][opTask];

  // forwarding: ascending ring scan, closest earlier store wins
  always_comb begin
    fwdHit = 1'b0; fwdVal = '0;
    for (int p = 0; p < NUM_TASKS; p++) begin
      if (hit && TASK_W'(p) <= opPos && stQ[hitIdx][taskAt[p]]) begin
        fwdHit = 1'b1; fwdVal = valQ[hitIdx][taskAt[p]];
      end
    end
  end

  assign loadValue = fwdHit ? fwdVal : memRdData;

  // violation search: later tasks nearest first, stop at an intervening store
  always_comb begin
    violation = 1'b0; blocked = 1'b0; violTask = '0; violPos = '1;
    for (int p = 0; p < NUM_TASKS; p++) begin
      if (hit && TASK_W'(p) > opPos && !blocked && !violation) begin
        if (ldQ[hitIdx][taskAt[p]]) begin
          violation = 1'b1; violTask = taskAt[p]; violPos = TASK_W'(p);
        end
        if (stQ[hitIdx][taskAt[p]]) blocked = 1'b1;
      end
    end
  end

  always_comb begin
    status.hit          = hit;
    status.freeAvail    = freeAvail;
    status.headHasStore = headHasStore;
    status.violation    = violation;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ldQ[i] <= '0;
        stQ[i] <= '0;
      end
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.loadEn;
      if (strobe.loadEn) rdData <= loadValue;
      if (strobe.storeEn && violation) begin
        for (int i = 0; i < ENTRIES; i++) begin
          for (int t = 0; t < NUM_TASKS; t++) begin
            if (clrMask[t]) begin
              ldQ[i][t] <= 1'b0;
              stQ[i][t] <= 1'b0;
            end
          end
        end
      end
      if (strobe.storeEn) stQ[selIdx][opTask] <= 1'b1;
      if (strobe.loadEn && !ownStore) ldQ[selIdx][opTask] <= 1'b1;
      if (strobe.drainWrEn) stQ[drainIdx][head] <= 1'b0;
      if (strobe.retireEn) begin
        for (int i = 0; i < ENTRIES; i++) ldQ[i][head] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if ((strobe.loadEn || strobe.storeEn) && !hit) tagQ[selIdx] <= opAddr;
    if (strobe.storeEn) valQ[selIdx][opTask] <= opData;
  end

  assign memRdAddr = opAddr;
  assign memWrEn   = strobe.drainWrEn;
  assign memWrAddr = tagQ[drainIdx];
  assign memWrData = valQ[drainIdx][head];

  // a store is held back, never written through next cycle
  assert_store_buffered_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeEn |=> !memWrEn);

  // nothing is accepted into a full table unless it matches
  assert_full_refuses_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEn || strobe.storeEn) |-> (hit || freeAvail));

  // an accepted load produces a result on the next cycle
  assert_load_answers_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEn |=> rdValid);

endmodule

// File: rtl/spec_ls_buffer.sv
module spec_ls_buffer
  import specbuf_pkg::*;
#(
  parameter int NUM_TASKS = 4,
  parameter int ENTRIES   = 16,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  localparam int TASK_W   = $clog2(NUM_TASKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic              opIsStore,
  input  logic [TASK_W-1:0] opTask,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  output logic              opReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              squashValid,
  output logic [TASK_W-1:0] squashTask,
  input  logic              commitReq,
  output logic [TASK_W-1:0] headTask,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);

  bufStrobe_t        strobe;
  bufStatus_t        status;
  logic [TASK_W-1:0] violTask;

  specbuf_ctrl #(.TASK_W(TASK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opIsStore(opIsStore),
    .commitReq(commitReq), .status(status), .violTask(violTask),
    .strobe(strobe), .head(headTask), .opReady(opReady),
    .squashValid(squashValid), .squashTask(squashTask)
  );

  specbuf_data #(
    .NUM_TASKS(NUM_TASKS), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .head(headTask),
    .opTask(opTask), .opAddr(opAddr), .opData(opData), .memRdData(memRdData),
    .status(status), .violTask(violTask), .rdValid(rdValid), .rdData(rdData),
    .memRdAddr(memRdAddr), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData)
  );

endmodule

// File: tb/spec_ls_buffer_bench.sv
module spec_ls_buffer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0, opIsStore = 1'b0, commitReq = 1'b0;
  logic [1:0]  opTask = '0;
  logic [15:0] opAddr = '0;
  logic [31:0] opData = '0;
  logic        opReady, rdValid, squashValid, memWrEn;
  logic [31:0] rdData, memRdData, memWrData;
  logic [1:0]  squashTask, headTask;
  logic [15:0] memRdAddr, memWrAddr;

  logic [31:0] mem [256];
  logic [15:0] wrAddrLog [8];
  logic [31:0] wrDataLog [8];
  int          wrCount = 0;
  int          nChecks = 0, nErr = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  spec_ls_buffer u_spec_ls_buffer (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opIsStore(opIsStore),
    .opTask(opTask), .opAddr(opAddr), .opData(opData), .opReady(opReady),
    .rdValid(rdValid), .rdData(rdData), .squashValid(squashValid),
    .squashTask(squashTask), .commitReq(commitReq), .headTask(headTask),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  assign memRdData = mem[memRdAddr[7:0]];

  always @(posedge clk) begin
    if (memWrEn) begin
      mem[memWrAddr[7:0]] <= memWrData;
      if (wrCount < 8) begin
        wrAddrLog[wrCount] <= memWrAddr;
        wrDataLog[wrCount] <= memWrData;
      end
      wrCount <= wrCount + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        isSt;
    logic [1:0]  tsk;
    logic [15:0] addr;
    logic [31:0] data;
    logic [31:0] expRd;
    logic        expSq;
    logic [1:0]  expSqTask;
    logic [3:0]  req;
  } vec_t;

  // memory holds 0x1000 + address; head is task 0 throughout
  localparam vec_t VECS [18] = '{
    '{1'b0, 2'd2, 16'h10, 32'h0,    32'h1010, 1'b0, 2'd0, 4'd1},  // R1 load from memory
    '{1'b1, 2'd0, 16'h10, 32'hAAAA, 32'h0,    1'b1, 2'd2, 4'd4},  // R4 squash task 2
    '{1'b0, 2'd2, 16'h10, 32'h0,    32'hAAAA, 1'b0, 2'd0, 4'd5},  // R5 reload after squash
    '{1'b1, 2'd2, 16'h10, 32'hBBBB, 32'h0,    1'b0, 2'd0, 4'd4},
    '{1'b0, 2'd3, 16'h10, 32'h0,    32'hBBBB, 1'b0, 2'd0, 4'd3},  // R3 nearest earlier
    '{1'b1, 2'd1, 16'h10, 32'hCCCC, 32'h0,    1'b1, 2'd2, 4'd4},  // R4 exposed load of task 2
    '{1'b0, 2'd3, 16'h10, 32'h0,    32'hCCCC, 1'b0, 2'd0, 4'd5},  // R5 task 2 store wiped
    '{1'b0, 2'd1, 16'h20, 32'h0,    32'h1020, 1'b0, 2'd0, 4'd1},
    '{1'b1, 2'd1, 16'h20, 32'h1111, 32'h0,    1'b0, 2'd0, 4'd2},
    '{1'b0, 2'd1, 16'h20, 32'h0,    32'h1111, 1'b0, 2'd0, 4'd3},  // R3 own store
    '{1'b1, 2'd0, 16'h20, 32'h2222, 32'h0,    1'b1, 2'd1, 4'd4},  // R4 task 1 loaded first
    '{1'b1, 2'd2, 16'h30, 32'h3333, 32'h0,    1'b0, 2'd0, 4'd2},
    '{1'b0, 2'd2, 16'h30, 32'h0,    32'h3333, 1'b0, 2'd0, 4'd6},
    '{1'b1, 2'd1, 16'h30, 32'h4444, 32'h0,    1'b0, 2'd0, 4'd6},  // R6 not recorded
    '{1'b0, 2'd3, 16'h30, 32'h0,    32'h3333, 1'b0, 2'd0, 4'd3},
    '{1'b1, 2'd0, 16'h30, 32'h5555, 32'h0,    1'b0, 2'd0, 4'd10}, // R10 shielded by task 1
    '{1'b0, 2'd0, 16'h10, 32'h0,    32'hAAAA, 1'b0, 2'd0, 4'd3},
    '{1'b0, 2'd3, 16'h10, 32'h0,    32'hAAAA, 1'b0, 2'd0, 4'd5}   // R5 tasks 1,2 cleared
  };

  task automatic doOp(input logic st, input logic [1:0] tk, input logic [15:0] a,
                      input logic [31:0] d, input string req);
    @(negedge clk);
    opValid = 1'b1; opIsStore = st; opTask = tk; opAddr = a; opData = d;
    #1 chk(req, {31'd0, opReady}, 32'd1);
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic waitHead(input logic [1:0] want);
    for (int k = 0; k < 20 && headTask != want; k++) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual=expired expected=finish");
    finishRun();
  end

  initial begin
    string req;
    for (int a = 0; a < 256; a++) mem[a] = 32'h1000 + a;

    // R9 reset state
    #1;
    chk("R9 head", {30'd0, headTask}, 32'd0);
    chk("R9 outputs", {29'd0, rdValid, squashValid, memWrEn}, 32'd0);
    chk("R9 ready", {31'd0, opReady}, 32'd1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // vector walk: R1 R3 R4 R5 R6 R10
    for (int i = 0; i < 18; i++) begin
      req = $sformatf("R%0d vec%0d", VECS[i].req, i);
      doOp(VECS[i].isSt, VECS[i].tsk, VECS[i].addr, VECS[i].data, req);
      chk(req, {31'd0, rdValid}, {31'd0, !VECS[i].isSt});
      if (!VECS[i].isSt) chk(req, rdData, VECS[i].expRd);
      chk(req, {31'd0, squashValid}, {31'd0, VECS[i].expSq});
      if (VECS[i].expSq) chk(req, {30'd0, squashTask}, {30'd0, VECS[i].expSqTask});
    end
    chk("R2 no write before commit", wrCount, 32'd0);

    // R7 commit head 0: slots 0x10, 0x20, 0x30 drained in slot order
    @(negedge clk);
    commitReq = 1'b1; opValid = 1'b1; opIsStore = 1'b0; opTask = 2'd1; opAddr = 16'h10;
    #1 chk("R7 stall on commit", {31'd0, opReady}, 32'd0);
    @(negedge clk);
    commitReq = 1'b0;
    #1 chk("R7 stall while draining", {31'd0, opReady}, 32'd0);
    opValid = 1'b0;
    waitHead(2'd1);
    chk("R7 head advanced", {30'd0, headTask}, 32'd1);
    chk("R7 write count", wrCount, 32'd3);
    chk("R7 write0 addr", {16'd0, wrAddrLog[0]}, 32'h10);
    chk("R7 write0 data", wrDataLog[0], 32'hAAAA);
    chk("R7 write1 addr", {16'd0, wrAddrLog[1]}, 32'h20);
    chk("R7 write1 data", wrDataLog[1], 32'h2222);
    chk("R7 write2 addr", {16'd0, wrAddrLog[2]}, 32'h30);
    chk("R7 write2 data", wrDataLog[2], 32'h5555);

    // R3 wrap: ring is now 1,2,3,0
    doOp(1'b0, 2'd1, 16'h30, 32'h0, "R3 head own");
    chk("R3 head own", rdData, 32'h4444);
    doOp(1'b0, 2'd0, 16'h30, 32'h0, "R3 wrap");
    chk("R3 wrap", rdData, 32'h3333);

    // R9 reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R9 head after reset", {30'd0, headTask}, 32'd0);
    chk("R9 outputs after reset", {29'd0, rdValid, squashValid, memWrEn}, 32'd0);
    chk("R9 ready after reset", {31'd0, opReady}, 32'd1);
    @(negedge clk);
    rstN = 1'b1;

    // R8 fill all 16 slots
    for (int i = 0; i < 16; i++) begin
      doOp(1'b0, 2'd0, 16'h40 + 16'(i), 32'h0, "R8 fill");
      chk("R8 fill data", rdData, 32'h1040 + i);
    end
    @(negedge clk);
    opValid = 1'b1; opIsStore = 1'b0; opTask = 2'd1; opAddr = 16'h50;
    #1 chk("R8 full new addr", {31'd0, opReady}, 32'd0);
    opAddr = 16'h45;
    #1 chk("R8 full resident addr", {31'd0, opReady}, 32'd1);
    opValid = 1'b0;
    @(negedge clk);
    commitReq = 1'b1;
    @(negedge clk);
    commitReq = 1'b0;
    waitHead(2'd1);
    opValid = 1'b1; opTask = 2'd2; opAddr = 16'h50;
    #1 chk("R8 freed by retire", {31'd0, opReady}, 32'd1);
    chk("R7 empty commit no write", wrCount, 32'd3);
    @(negedge clk);
    opValid = 1'b0;
    @(negedge clk);
    finishRun();
  end

endmodule